// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides which pending exception a 32-bit embedded core takes. It then performs the whole entry in one clock edge. Six request lines are ranked by a fixed priority. The winner selects a vector offset. A prefix bit in the machine-state word chooses whether that offset is placed in the low or the high 1 MiB of the address space. In the same cycle, the address of the instruction that would have run next is saved, a filtered copy of the machine-state word is saved, and the machine-state word is rewritten for handler entry.

The block owns the machine-state word together with both save registers. The core writes the state word through a plain write strobe and ends a handler with a return pulse. The return pulse copies the low half of the saved state back into the state word. On the first clock after reset is released, the block performs a boot step. It sets the vector prefix from the inverted initial-prefix bit of the reset configuration word and presents the reset vector.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bit 0 (debug nonmaskable) has the highest priority. Bit 1 (system reset), bit 2 (instruction-related), bit 3 (breakpoint), bit 4 (external) and bit 5 (decrementer) follow in that order. Only the highest enabled request is taken per cycle. A request stays pending until its source drops it.
- R2: Requests 4 and 5 are ignored while the enable bit of the state word (bit 15, LSB-0) is 0. In that case `taken_o` stays low and the state word is unchanged.
- R3: The vector offsets are 0x01F00 for debug, 0x00100 for reset, `instr_off_i` for instruction-related, 0x01D00 for breakpoint, 0x00500 for external and 0x00900 for decrementer. The offset fills `vec_o[19:0]`.
- R4: `vec_o[31:20]` is 0xFFF when the prefix bit of the state word (bit 6) is 1, and 0x000 when it is 0.
- R5: On entry, `srr0_o` takes `next_pc_i`.
- R6: On entry, `srr1_o` takes the old state word ANDed with 0x87C0FFFF. Its other bits are always 0.
- R7: On entry, the state word keeps bit 16 (little-endian select), bit 12 (machine-check enable) and bit 6 (prefix). Bit 0 takes the old bit 16. All other bits are cleared.
- R8: While `rst_ni` is low, all outputs are 0. On the first clock after release, the state word becomes 0 except bit 6, which becomes `!cfg_iip_i`. `vec_o` becomes the prefix base plus 0x00100, and `taken_o` pulses. Requests are not taken on that edge.
- R9: All results appear one clock after the request is sampled. `taken_o` is high for exactly that one cycle per entry.
- R10: When `rfi_i` is high and nothing is taken, state word bits 15:0 load `srr1_o[15:0]` and bits 31:16 are kept.
- R11: The precedence on one edge is entry, then return, then the state write. `msr_we_i` loads `msr_wdata_i` only when neither of the others acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Pending exception requests, bit 0 highest |
| instr_off_i | input | 20 | Vector offset for the instruction-related exception |
| next_pc_i | input | 32 | Address of the next instruction to execute |
| cfg_iip_i | input | 1 | Initial-prefix bit of the reset configuration word |
| rfi_i | input | 1 | Return-from-handler pulse |
| msr_we_i | input | 1 | State word write strobe |
| msr_wdata_i | input | 32 | State word write data |
| vec_o | output | 32 | Vector address of the last entry |
| srr0_o | output | 32 | Saved next-instruction address |
| srr1_o | output | 32 | Saved filtered state word |
| msr_o | output | 32 | Current state word |
| taken_o | output | 1 | One-cycle pulse per entry or boot step |

## Verification
Every internal register drives a port directly. An error in the grant, the offset or the prefix therefore shows in `vec_o` one clock after the request. A wrong keep or clear rule shows at once in `msr_o` and `srr1_o`. A stale or wrong enable bit has a later effect: external requests are then accepted when they should be ignored, or ignored when they should be taken, from the next edge onward. A fault in the return path shows only after a handler return, as low state bits that differ from the saved copy.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN  = 32;
  localparam int NSRC  = 6;
  localparam int OFF_W = 20;
  localparam int PFX_W = XLEN - OFF_W;
  localparam int RFI_W = 16;

  localparam int SRC_DEV = 0;
  localparam int SRC_RST = 1;
  localparam int SRC_INS = 2;
  localparam int SRC_BRK = 3;
  localparam int SRC_EXT = 4;
  localparam int SRC_DEC = 5;

  // big-endian field numbers mapped to LSB-0 indices
  function automatic int le_idx(int be);
    return XLEN - 1 - be;
  endfunction

  localparam int MSR_POW = le_idx(13);
  localparam int MSR_ILE = le_idx(15);
  localparam int MSR_EE  = le_idx(16);
  localparam int MSR_ME  = le_idx(19);
  localparam int MSR_IP  = le_idx(25);
  localparam int MSR_LE  = le_idx(31);

  localparam logic [XLEN-1:0] SRR1_COPY = 32'h87C0_FFFF;
  localparam logic [XLEN-1:0] MSR_KEEP  = (XLEN'(1) << MSR_ILE) |
                                          (XLEN'(1) << MSR_ME)  |
                                          (XLEN'(1) << MSR_IP);
  localparam logic [NSRC-1:0] MASKABLE  = (NSRC'(1) << SRC_EXT) |
                                          (NSRC'(1) << SRC_DEC);

  function automatic logic [OFF_W-1:0] src_off(int src);
    case (src)
      SRC_DEV: return OFF_W'(20'h01F00);
      SRC_RST: return OFF_W'(20'h00100);
      SRC_BRK: return OFF_W'(20'h01D00);
      SRC_EXT: return OFF_W'(20'h00500);
      SRC_DEC: return OFF_W'(20'h00900);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int              N        = 6,
  parameter logic [N-1:0]    MASK_SET = '0
) (
  input  logic [N-1:0] req_i,
  input  logic         en_i,
  output logic [N-1:0] grant_o
);
  logic [N-1:0] live;
  logic [N-1:0] seen;

  assign live    = req_i & ~(MASK_SET & {N{~en_i}});
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i] = live[i] & ~seen[i];
    if (i < N - 1) begin : g_seen
      assign seen[i+1] = seen[i] | live[i];
    end
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_pkg::*;
(
  input  logic [NSRC-1:0]  sel_i,
  input  logic             ip_i,
  input  logic [OFF_W-1:0] ins_off_i,
  output logic [XLEN-1:0]  vec_o
);
  logic [OFF_W-1:0] off;

  always_comb begin
    off = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i[i]) off = off | ((i == SRC_INS) ? ins_off_i : src_off(i));
    end
  end

  assign vec_o = {{PFX_W{ip_i}}, off};
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o
);
  assign srr1_o = msr_i & SRR1_COPY;

  always_comb begin
    msr_o         = msr_i & MSR_KEEP;
    msr_o[MSR_LE] = msr_i[MSR_ILE];
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  req_i,
  input  logic [OFF_W-1:0] instr_off_i,
  input  logic [XLEN-1:0]  next_pc_i,
  input  logic             cfg_iip_i,
  input  logic             rfi_i,
  input  logic             msr_we_i,
  input  logic [XLEN-1:0]  msr_wdata_i,
  output logic [XLEN-1:0]  vec_o,
  output logic [XLEN-1:0]  srr0_o,
  output logic [XLEN-1:0]  srr1_o,
  output logic [XLEN-1:0]  msr_o,
  output logic             taken_o
);
  logic            boot_q;
  logic [XLEN-1:0] msr_q, srr0_q, srr1_q, vec_q;
  logic            taken_q;
  logic [NSRC-1:0] grant, sel;
  logic            ip_sel;
  logic [XLEN-1:0] vec_nxt, srr1_nxt, msr_nxt, boot_msr;

  exc_prio_arb #(.N(NSRC), .MASK_SET(MASKABLE)) u_arb (
    .req_i   (req_i),
    .en_i    (msr_q[MSR_EE]),
    .grant_o (grant)
  );

  // boot step reuses the vector path with the reset source forced
  assign sel    = boot_q ? (NSRC'(1) << SRC_RST) : grant;
  assign ip_sel = boot_q ? ~cfg_iip_i : msr_q[MSR_IP];

  exc_vec_gen u_vec (
    .sel_i     (sel),
    .ip_i      (ip_sel),
    .ins_off_i (instr_off_i),
    .vec_o     (vec_nxt)
  );

  exc_state_calc u_state (
    .msr_i  (msr_q),
    .srr1_o (srr1_nxt),
    .msr_o  (msr_nxt)
  );

  always_comb begin
    boot_msr         = '0;
    boot_msr[MSR_IP] = ~cfg_iip_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= 1'b1;
      msr_q   <= '0;
      srr0_q  <= '0;
      srr1_q  <= '0;
      vec_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= 1'b0;
      if (boot_q) begin
        boot_q  <= 1'b0;
        msr_q   <= boot_msr;
        vec_q   <= vec_nxt;
        taken_q <= 1'b1;
      end else if (|grant) begin
        srr0_q  <= next_pc_i;
        srr1_q  <= srr1_nxt;
        msr_q   <= msr_nxt;
        vec_q   <= vec_nxt;
        taken_q <= 1'b1;
      end else if (rfi_i) begin
        msr_q[RFI_W-1:0] <= srr1_q[RFI_W-1:0];
      end else if (msr_we_i) begin
        msr_q <= msr_wdata_i;
      end
    end
  end

  assign vec_o   = vec_q;
  assign srr0_o  = srr0_q;
  assign srr1_o  = srr1_q;
  assign msr_o   = msr_q;
  assign taken_o = taken_q;

  assert_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_q && !msr_o[MSR_EE] && ((req_i & ~MASKABLE) == '0)) |=> !taken_o);

  assert_prefix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (vec_o[XLEN-1:OFF_W] == {PFX_W{msr_o[MSR_IP]}}));

  assert_srr0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_q && (|grant)) |=> (srr0_o == $past(next_pc_i)));

  assert_srr1_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srr1_o & ~SRR1_COPY) == '0);

  assert_entry_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (!msr_o[MSR_EE] && !msr_o[MSR_POW]));

  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_q && (grant == '0)) |=> !taken_o);

  assert_rfi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_q && (grant == '0) && rfi_i) |=>
      (msr_o == {$past(msr_o[XLEN-1:RFI_W]), $past(srr1_o[RFI_W-1:0])}));
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [5:0]  req;
    logic [31:0] msr;
    logic [19:0] ioff;
    logic        tk;
    logic [31:0] vec;
  } row_t;

  localparam row_t TBL [10] = '{
    '{6'b000001, 32'h0000_8040, 20'h00000, 1'b1, 32'hFFF0_1F00},
    '{6'b111110, 32'h0000_8000, 20'h00000, 1'b1, 32'h0000_0100},
    '{6'b111100, 32'h0000_8040, 20'h00700, 1'b1, 32'hFFF0_0700},
    '{6'b111000, 32'h0000_8000, 20'h00000, 1'b1, 32'h0000_1D00},
    '{6'b110000, 32'h0001_8040, 20'h00000, 1'b1, 32'hFFF0_0500},
    '{6'b100000, 32'h0000_8000, 20'h00000, 1'b1, 32'h0000_0900},
    '{6'b110000, 32'h0000_0040, 20'h00000, 1'b0, 32'h0000_0000},
    '{6'b100000, 32'h0000_0000, 20'h00000, 1'b0, 32'h0000_0000},
    '{6'b001100, 32'h0000_0000, 20'h00300, 1'b1, 32'h0000_0300},
    '{6'b000011, 32'hFFFF_FFFF, 20'h00000, 1'b1, 32'hFFF0_1F00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  req = '0;
  logic [19:0] ioff = '0;
  logic [31:0] npc = '0;
  logic        iip = 1'b0;
  logic        rfi = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] vec, srr0, srr1, msr;
  logic        taken;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  exc_entry_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .instr_off_i(ioff),
    .next_pc_i(npc), .cfg_iip_i(iip), .rfi_i(rfi), .msr_we_i(we),
    .msr_wdata_i(wdata), .vec_o(vec), .srr0_o(srr0), .srr1_o(srr1),
    .msr_o(msr), .taken_o(taken)
  );

  function automatic logic [31:0] x_srr1(logic [31:0] m);
    return m & 32'h87C0_FFFF;
  endfunction

  function automatic logic [31:0] x_msr(logic [31:0] m);
    return (m & 32'h0001_1040) | {31'b0, m[16]};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic wr_msr(logic [31:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic do_reset(logic b);
    @(negedge clk); rst_n = 1'b0; iip = b;
    @(negedge clk);
    chk("R8 reset vec", vec, 32'h0);
    chk("R8 reset msr", msr, 32'h0);
    chk("R8 reset taken", {31'b0, taken}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 boot taken", {31'b0, taken}, 32'h1);
    chk("R8 boot msr", msr, b ? 32'h0 : 32'h40);
    chk("R8 boot vec", vec, b ? 32'h0000_0100 : 32'hFFF0_0100);
    @(negedge clk);
    chk("R9 boot pulse ends", {31'b0, taken}, 32'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);

    // table: R1 priority, R2 masking, R3 offsets, R4 prefix, R5-R7 entry
    for (int i = 0; i < 10; i++) begin
      wr_msr(TBL[i].msr);
      req = TBL[i].req; ioff = TBL[i].ioff; npc = 32'h1000_0000 + 32'(i * 4);
      @(negedge clk);
      req = '0;
      chk("R1 taken", {31'b0, taken}, {31'b0, TBL[i].tk});
      if (TBL[i].tk) begin
        chk("R3 R4 vec", vec, TBL[i].vec);
        chk("R5 srr0", srr0, 32'h1000_0000 + 32'(i * 4));
        chk("R6 srr1", srr1, x_srr1(TBL[i].msr));
        chk("R7 msr", msr, x_msr(TBL[i].msr));
      end else begin
        chk("R2 msr untouched", msr, TBL[i].msr);
      end
      @(negedge clk);
      chk("R9 single pulse", {31'b0, taken}, 32'h0);
    end

    // return path R10 and precedence R11
    wr_msr(32'h0000_9072);
    req = 6'b000001; npc = 32'h2000;
    @(negedge clk); req = '0;
    chk("R6 srr1 pre-rfi", srr1, 32'h0000_9072);
    chk("R7 msr pre-rfi", msr, 32'h0000_1040);
    wr_msr(32'hABCD_0000);
    rfi = 1'b1;
    @(negedge clk); rfi = 1'b0;
    chk("R10 rfi restore", msr, 32'hABCD_9072);
    rfi = 1'b1; we = 1'b1; wdata = 32'h5555_5555;
    @(negedge clk); rfi = 1'b0; we = 1'b0;
    chk("R11 rfi over write", msr, 32'hABCD_9072);
    rfi = 1'b1; req = 6'b000001; npc = 32'h3000;
    @(negedge clk); rfi = 1'b0; req = '0;
    chk("R11 entry over rfi taken", {31'b0, taken}, 32'h1);
    chk("R11 entry over rfi msr", msr, x_msr(32'hABCD_9072));
    chk("R11 entry over rfi srr1", srr1, x_srr1(32'hABCD_9072));

    // held maskable request: taken once, then masked by cleared enable
    wr_msr(32'h0000_8000);
    req = 6'b110000;
    @(negedge clk);
    chk("R1 held ext taken", {31'b0, taken}, 32'h1);
    chk("R3 held ext vec", vec, 32'h0000_0500);
    @(negedge clk);
    chk("R2 held ext masked", {31'b0, taken}, 32'h0);
    req = '0;
    @(negedge clk);

    // held nonmaskable request retaken while pending
    req = 6'b000100; ioff = 20'h00400;
    @(negedge clk);
    chk("R1 pending first", {31'b0, taken}, 32'h1);
    @(negedge clk);
    chk("R1 pending again", {31'b0, taken}, 32'h1);
    req = '0;

    do_reset(1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule